// File: doc/BRIEF.md
# Serial Configuration Word Receiver

This block is the receiving end of a three-wire configuration port made of a serial clock, a serial data line and a latch-enable line. A host raises latch enable and presents one data bit on each rising edge of the serial clock, most significant bit first. After 24 bits it drops latch enable. The block then loads the collected word into one of four control registers: reference divider, receive oscillator, transmit oscillator or operating mode. The two lowest bits of the word choose the register.

The three serial lines are asynchronous to the system clock. Each one passes through a synchroniser chain inside the block, and the block detects their edges in the system clock domain. A frame with the wrong bit count is dropped and sets an error flag that stays set. Each register has an output that pulses for one cycle when the register is written, so downstream logic can act on a new value. After reset, the reference register holds the divider word 0x0043C0 and the other registers hold zero.

Top module: `cfg_serial_rx`

## Requirements
- R1: A data bit is taken only on a rising serial clock edge while latch enable is high. The first bit taken ends up as bit 23 of the stored word and the last as bit 0.
- R2: Stored-word bits [1:0] pick the destination: 0 = reference (regs_o[0]), 1 = receive oscillator (regs_o[1]), 2 = transmit oscillator (regs_o[2]), 3 = mode (regs_o[3]).
- R3: On the falling edge of latch enable after exactly 24 bits, the whole 24-bit word, select bits included, is copied into the chosen register.
- R4: Reset sets regs_o[0] to 0x0043C0, regs_o[1..3] to 0, upd_o to 0 and frame_err_o to 0.
- R5: Each accepted frame raises exactly one upd_o bit, the one for the written register, for exactly one system clock cycle. The new register value is visible in that same cycle.
- R6: A frame that ends after any bit count other than 24 (for example 23 or 25) changes no register, raises no upd_o bit and sets frame_err_o.
- R7: Serial clock edges while latch enable is low neither shift nor count. A correct frame that follows them is stored exactly.
- R8: frame_err_o stays high until reset. Correct frames after an error are still accepted.
- R9: A write leaves the three registers it does not select unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host (asynchronous) |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch enable, high during a frame |
| regs_o | output | 4x24 | Control registers, index = select code |
| upd_o | output | 4 | One-cycle write strobe per register |
| frame_err_o | output | 1 | Sticky bad-length frame flag |

## Verification
The assertions check on every cycle that at most one strobe is high, that each strobe lasts a single cycle, and that a register only changes in a cycle where its strobe is high. They also check that a latch-enable fall produces exactly one strobe when the count is right and no strobe plus the error flag when it is wrong, and that the error flag never drops. The bench scenarios are needed for the content: that bits arrive MSB first, that each select code maps to the right register, that the reset values are correct, and that serial clock activity with latch enable low leaves a later frame intact.

// File: rtl/cfgport_pkg.sv
`timescale 1ns/1ps
package cfgport_pkg;
   localparam int SEL_W = 2;
   localparam int NREG  = 1 << SEL_W;

   typedef enum logic [SEL_W-1:0] {
      SEL_REF   = 2'd0,
      SEL_RXOSC = 2'd1,
      SEL_TXOSC = 2'd2,
      SEL_MODE  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/cfgport_sync.sv
`timescale 1ns/1ps
module cfgport_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cfgport_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("cfgport_sync: W must be positive");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/cfgport_shifter.sv
`timescale 1ns/1ps
module cfgport_shifter #(
   parameter int WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              le_i,
   input  logic              shift_i,
   input  logic              bit_i,
   output logic [WORD_W-1:0] word_o,
   output logic              full_o
);
   localparam int CNT_W = $clog2(WORD_W + 2);
   localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_WORD = CNT_W'(WORD_W);

   if (WORD_W < 2) begin : g_bad_word
      $error("cfgport_shifter: WORD_W too small");
   end

   logic [WORD_W-1:0] shreg;
   logic [CNT_W-1:0]  cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         cnt   <= '0;
      end else if (!le_i) begin
         cnt <= '0;
      end else if (shift_i) begin
         shreg <= {shreg[WORD_W-2:0], bit_i};
         if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
      end
   end

   assign word_o = shreg;
   assign full_o = (cnt == CNT_WORD);
endmodule

// File: rtl/cfgport_bank.sv
`timescale 1ns/1ps
module cfgport_bank
   import cfgport_pkg::*;
#(
   parameter int              WORD_W    = 24,
   parameter logic [WORD_W-1:0] REF_RESET = 24'h0043C0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_i,
   input  logic [WORD_W-1:0]           word_i,
   output logic [NREG-1:0][WORD_W-1:0] regs_o,
   output logic [NREG-1:0]             upd_o
);
   if (WORD_W <= SEL_W) begin : g_bad_word
      $error("cfgport_bank: WORD_W must exceed select width");
   end

   reg_sel_e sel;
   assign sel = reg_sel_e'(word_i[SEL_W-1:0]);

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic [WORD_W-1:0] rst_val;
      logic              hit;

      if (r == int'(SEL_REF)) begin : g_ref_init
         assign rst_val = REF_RESET;
      end else begin : g_zero_init
         assign rst_val = '0;
      end

      assign hit = wr_i && (sel == reg_sel_e'(r));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs_o[r] <= rst_val;
            upd_o[r]  <= 1'b0;
         end else begin
            upd_o[r] <= hit;
            if (hit) regs_o[r] <= word_i;
         end
      end

      AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
         upd_o[r] |=> !upd_o[r]); // R5
      AST_HOLD_UNLESS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
         !upd_o[r] |-> $stable(regs_o[r])); // R9
   end

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(upd_o)); // R5
endmodule

// File: rtl/cfg_serial_rx.sv
`timescale 1ns/1ps
module cfg_serial_rx
   import cfgport_pkg::*;
#(
   parameter int                WORD_W      = 24,
   parameter int                SYNC_STAGES = 2,
   parameter logic [WORD_W-1:0] REF_RESET   = 24'h0043C0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ser_clk,
   input  logic                        ser_dat,
   input  logic                        ser_le,
   output logic [NREG-1:0][WORD_W-1:0] regs_o,
   output logic [NREG-1:0]             upd_o,
   output logic                        frame_err_o
);
   if (WORD_W % 8 != 0) begin : g_bad_bytes
      $error("cfg_serial_rx: WORD_W must be whole bytes");
   end

   logic [2:0] raw, synced;
   logic       sck_s, dat_s, le_s;
   logic       sck_prev, le_prev;
   logic       sck_rise, le_fall;
   logic [WORD_W-1:0] word;
   logic       full;
   logic       commit;

   assign raw = {ser_le, ser_dat, ser_clk};

   cfgport_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw),
      .q_o   (synced)
   );

   assign {le_s, dat_s, sck_s} = synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_prev <= 1'b0;
         le_prev  <= 1'b0;
      end else begin
         sck_prev <= sck_s;
         le_prev  <= le_s;
      end
   end

   assign sck_rise = sck_s & ~sck_prev;
   assign le_fall  = le_prev & ~le_s;

   cfgport_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .le_i    (le_s),
      .shift_i (sck_rise),
      .bit_i   (dat_s),
      .word_o  (word),
      .full_o  (full)
   );

   assign commit = le_fall & full;

   cfgport_bank #(.WORD_W(WORD_W), .REF_RESET(REF_RESET)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (commit),
      .word_i (word),
      .regs_o (regs_o),
      .upd_o  (upd_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                frame_err_o <= 1'b0;
      else if (le_fall && !full) frame_err_o <= 1'b1;
   end

   AST_GOOD_FRAME_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (le_fall && full) |=> ($countones(upd_o) == 1)); // R3
   AST_BAD_FRAME_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (le_fall && !full) |=> (upd_o == '0 && frame_err_o)); // R6
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o |=> frame_err_o); // R8
endmodule

// File: tb/cfg_serial_rx_test.sv
`timescale 1ns/1ps
module cfg_serial_rx_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
   logic [3:0][23:0] regs_o;
   logic [3:0]       upd_o;
   logic             frame_err_o;

   int n_chk = 0, n_bad = 0;
   int pulses [4];
   int doubles [4];
   logic [3:0] upd_prev = '0;
   logic [23:0] exp_r [4];

   always #5 clk = ~clk;

   cfg_serial_rx uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_le(ser_le), .regs_o(regs_o), .upd_o(upd_o), .frame_err_o(frame_err_o)
   );

   always @(negedge clk) begin
      for (int i = 0; i < 4; i++) begin
         if (upd_o[i]) pulses[i] = pulses[i] + 1;
         if (upd_o[i] && upd_prev[i]) doubles[i] = doubles[i] + 1;
      end
      upd_prev = upd_o;
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
      end
   endtask

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   task automatic clear_pulses();
      for (int i = 0; i < 4; i++) begin pulses[i] = 0; doubles[i] = 0; end
   endtask

   task automatic send(input logic [31:0] data, input int nbits);
      ser_le = 1'b1;
      wait_clk(4);
      for (int i = nbits - 1; i >= 0; i--) begin
         ser_dat = data[i];
         wait_clk(4);
         ser_clk = 1'b1;
         wait_clk(4);
         ser_clk = 1'b0;
      end
      wait_clk(4);
      ser_le = 1'b0;
      wait_clk(12);
   endtask

   task automatic check_all_regs(input string tag);
      for (int i = 0; i < 4; i++)
         check(regs_o[i] === exp_r[i], tag, {8'h0, regs_o[i]}, {8'h0, exp_r[i]});
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(2);
      exp_r[0] = 24'h0043C0; exp_r[1] = '0; exp_r[2] = '0; exp_r[3] = '0;
   endtask

   task automatic t_reset();
      do_reset();
      check_all_regs("R4 reset value");
      check(upd_o === 4'b0, "R4 strobes idle", {28'h0, upd_o}, 32'h0);
      check(frame_err_o === 1'b0, "R4 error clear", {31'h0, frame_err_o}, 32'h0);
   endtask

   task automatic t_write(input logic [23:0] w, input string tag);
      int tgt;
      tgt = int'(w[1:0]);
      clear_pulses();
      send({8'h0, w}, 24);
      exp_r[tgt] = w;
      check_all_regs({tag, " R2 R3 R9 register contents"});
      for (int i = 0; i < 4; i++) begin
         check(pulses[i] == ((i == tgt) ? 1 : 0), {tag, " R5 strobe count"}, pulses[i], (i == tgt) ? 1 : 0);
         check(doubles[i] == 0, {tag, " R5 strobe width"}, doubles[i], 0);
      end
   endtask

   task automatic t_idle_clocks();
      ser_le = 1'b0;
      for (int k = 0; k < 7; k++) begin
         ser_dat = k[0];
         wait_clk(4); ser_clk = 1'b1; wait_clk(4); ser_clk = 1'b0;
      end
      wait_clk(8);
      check_all_regs("R7 idle serial clocks no write");
      t_write(24'h3C96A6, "R7 frame after idle clocks");
   endtask

   task automatic t_bad_len(input logic [31:0] data, input int nbits, input string tag);
      clear_pulses();
      send(data, nbits);
      check_all_regs({tag, " R6 registers unchanged"});
      check((pulses[0] + pulses[1] + pulses[2] + pulses[3]) == 0, {tag, " R6 no strobe"},
            pulses[0] + pulses[1] + pulses[2] + pulses[3], 0);
      check(frame_err_o === 1'b1, {tag, " R6 error set"}, {31'h0, frame_err_o}, 32'h1);
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_write(24'h123455, "rx osc");
      t_write(24'hABCDEE, "tx osc");
      t_write(24'h0F0F0F, "mode");
      t_write(24'hFEDCB8, "reference");
      t_write(24'h800001, "R1 msb first");
      t_idle_clocks();
      t_bad_len(32'h00555555, 23, "short frame");
      t_bad_len(32'h01AAAAAA, 25, "long frame");
      t_write(24'h5A5A5B, "R8 write after error");
      check(frame_err_o === 1'b1, "R8 error stays set", {31'h0, frame_err_o}, 32'h1);
      t_reset();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule